// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single-byte requests from inside the chip into the strobe pattern a NAND flash device expects on its pins. Each request names one of four kinds of bus cycle: command, address, data write or data read. It also carries a byte. The sequencer drives:

- the active-low chip select,
- the active-high command and address latch lines,
- the active-low write and read strobes,
- the output half of the 8-bit data bus, together with its output enable.

For read cycles it samples the input half of the bus and returns the byte with a one-cycle valid pulse.

The sequencer clock runs at twice the system rate, so one tick is half a system clock. Every spacing the flash needs, including the half-clock ones, becomes a whole number of ticks. A write-strobe extension field and a read-strobe extension field set the strobe low width separately. The strobe-high recovery between cycles is fixed. An extra turnaround is inserted when a read follows a write-strobe cycle.

A request is presented with `req_valid` and is taken on the rising edge where `busy` is low. Chip select stays asserted across back-to-back requests. It is released only after the hold time once no further request is waiting.

Top module: `nfseq_top`

## Requirements
- R1: After reset, the outputs are idle: `ce_n`=1, `we_n`=1, `re_n`=1, `cle`=0, `ale`=0, `dq_oe`=0, `busy`=0 and `rd_valid`=0.
- R2: Chip select falls 2 ticks before the strobe when a cycle starts from idle. It stays low for 6 ticks after the last strobe rises, then returns high.
- R3: The write strobe stays low for 2*(`wr_dly`+1) ticks. The read strobe stays low for 2*(`rd_dly`+1) ticks. The two strobes are never low together.
- R4: When requests follow each other, the strobe stays high for 8 ticks between cycles and chip select does not rise.
- R5: `req_kind` 00 is a command cycle and drives `cle`; 01 is an address cycle and drives `ale`; 10 is a data write and drives neither. Each latch line is high when the write strobe falls and stays high for 5 ticks after it rises.
- R6: Kinds 00, 01 and 10 use the write strobe. For these, `dq_oe` is high and `dq_out` carries the request byte from 2 ticks before the write strobe falls until 5 ticks after it rises.
- R7: Kind 11 is a read. It uses the read strobe and holds `dq_oe` low. `dq_in` is sampled at the clock edge on which the read strobe rises. `rd_valid` is high for exactly one cycle with that byte on `rd_data`.
- R8: A read strobe falls no earlier than 10 ticks after the previous write-strobe rise.
- R9: `busy` is low only in idle and in the final recovery tick. A request held while `busy` is high is not started early.
- R10: The strobe extension is taken from `wr_dly` or `rd_dly` when the request is accepted. A later change to these inputs does not affect a cycle already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the system rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_byte | input | 8 | Byte to place on the bus for write-strobe kinds |
| wr_dly | input | 4 | Write strobe extension |
| rd_dly | input | 4 | Read strobe extension |
| busy | output | 1 | High while a new request cannot be taken |
| rd_valid | output | 1 | One-cycle pulse with a captured read byte |
| rd_data | output | 8 | Captured read byte |
| ce_n | output | 1 | Chip select, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | 8 | Data bus input value |

## Verification
The bench drives the following patterns:

- A lone command and a lone address cycle, each started from idle, with different write extensions. These separate the lead, low width and hold counts and show which latch line goes with which kind.
- Back-to-back data writes. These expose the recovery spacing and show whether chip select stays low between cycles.
- Reads that start from idle after a write and reads that follow another read. These tell the turnaround lead apart from the plain lead.
- A write followed at once by a read. This pins the turnaround gap to exactly 10 ticks.

The read data on `dq_in` is valid only in the last low tick of the read strobe. A capture on any other edge therefore returns the wrong byte.

Changing the extension field mid-cycle and using the largest extension show whether the field is latched at acceptance and whether the width counter reaches its full range.

// File: rtl/nfseq_pkg.sv
// Shared types for the NAND flash bus cycle sequencer.
// Assumes: request kind is a 2-bit code decoded identically everywhere.
package nfseq_pkg;
    typedef enum logic [1:0] {
        KIND_CMD   = 2'b00,
        KIND_ADDR  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_READ  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_SETUP = 2'b01,
        PH_LOW   = 2'b10,
        PH_REC   = 2'b11
    } phase_e;
endpackage

// File: rtl/nfseq_phase_len.sv
// Phase length calculator: gives the terminal down-counter value for the
// setup phase of an incoming request and for the strobe-low phase of the
// cycle in progress.
// Assumes: counter counts from (length-1) down to 0; TURN_TICKS >= LEAD_TICKS.
module nfseq_phase_len #(
    parameter int DLY_W      = 4,
    parameter int CNT_W      = 6,
    parameter int LEAD_TICKS = 2,
    parameter int TURN_TICKS = 4
) (
    input  nfseq_pkg::kind_e   next_kind,
    input  logic               last_was_we,
    input  logic [DLY_W-1:0]   cur_dly,
    output logic [CNT_W-1:0]   setup_last,
    output logic [CNT_W-1:0]   low_last
);
    import nfseq_pkg::*;

    // Setup is stretched when a read strobe would follow a write strobe.
    always_comb begin
        if (next_kind == KIND_READ && last_was_we)
            setup_last = CNT_W'(TURN_TICKS - 1);
        else
            setup_last = CNT_W'(LEAD_TICKS - 1);
    end

    // Strobe low width is 2*(dly+1) ticks, so the last count is 2*dly+1.
    always_comb begin
        low_last = CNT_W'({cur_dly, 1'b1});
    end
endmodule

// File: rtl/nfseq_ctrl.sv
// Cycle controller: accepts one request at a time and walks it through
// setup, strobe-low and recovery phases, timing each with a down-counter.
// Assumes: requests are taken only when busy is low; delay fields are
// captured at acceptance.
module nfseq_ctrl #(
    parameter int DATA_W    = 8,
    parameter int DLY_W     = 4,
    parameter int CNT_W     = 6,
    parameter int REC_TICKS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  nfseq_pkg::kind_e    req_kind,
    input  logic [DATA_W-1:0]   req_byte,
    input  logic [DLY_W-1:0]    wr_dly,
    input  logic [DLY_W-1:0]    rd_dly,
    input  logic [CNT_W-1:0]    setup_last,
    input  logic [CNT_W-1:0]    low_last,
    output nfseq_pkg::phase_e   phase,
    output logic [CNT_W-1:0]    cnt,
    output nfseq_pkg::kind_e    cur_kind,
    output logic [DATA_W-1:0]   cur_byte,
    output logic [DLY_W-1:0]    cur_dly,
    output logic                last_was_we,
    output logic                busy
);
    import nfseq_pkg::*;

    logic accept;
    logic phase_done;

    // Free only in idle or in the last recovery tick.
    always_comb begin
        phase_done = (cnt == '0);
        busy       = !(phase == PH_IDLE || (phase == PH_REC && phase_done));
        accept     = req_valid && !busy;
    end

    // Phase sequencing, request capture and last-strobe bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            cnt         <= '0;
            cur_kind    <= KIND_CMD;
            cur_byte    <= '0;
            cur_dly     <= '0;
            last_was_we <= 1'b0;
        end else begin
            if (accept) begin
                cur_kind <= req_kind;
                cur_byte <= req_byte;
                cur_dly  <= (req_kind == KIND_READ) ? rd_dly : wr_dly;
            end
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase <= PH_SETUP;
                        cnt   <= setup_last;
                    end
                end
                PH_SETUP: begin
                    if (phase_done) begin
                        phase <= PH_LOW;
                        cnt   <= low_last;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (phase_done) begin
                        phase       <= PH_REC;
                        cnt         <= CNT_W'(REC_TICKS - 1);
                        last_was_we <= (cur_kind != KIND_READ);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (!phase_done) begin
                        cnt <= cnt - 1'b1;
                    end else if (accept) begin
                        phase <= PH_SETUP;
                        cnt   <= setup_last;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/nfseq_pins.sv
// Pin decoder and read capture: derives the flash control lines and bus
// enable from the controller state, and registers the read byte on the
// edge that ends the read strobe.
// Assumes: recovery counter runs REC_TICKS-1 down to 0; HOLD_TICKS < REC_TICKS.
module nfseq_pins #(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 6,
    parameter int REC_TICKS  = 6,
    parameter int HOLD_TICKS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  nfseq_pkg::phase_e   phase,
    input  logic [CNT_W-1:0]    cnt,
    input  nfseq_pkg::kind_e    cur_kind,
    input  logic [DATA_W-1:0]   cur_byte,
    input  logic [DATA_W-1:0]   dq_in,
    output logic                ce_n,
    output logic                cle,
    output logic                ale,
    output logic                we_n,
    output logic                re_n,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);
    import nfseq_pkg::*;

    localparam logic [CNT_W-1:0] HOLD_FLOOR = CNT_W'(REC_TICKS - HOLD_TICKS);

    logic is_read;
    logic in_hold;
    logic drive_win;

    // Strobe and latch-line decode from the current phase.
    always_comb begin
        is_read   = (cur_kind == KIND_READ);
        in_hold   = (phase == PH_REC) && (cnt >= HOLD_FLOOR);
        drive_win = (phase == PH_SETUP) || (phase == PH_LOW) || in_hold;
        ce_n      = (phase == PH_IDLE);
        we_n      = !((phase == PH_LOW) && !is_read);
        re_n      = !((phase == PH_LOW) && is_read);
        cle       = drive_win && (cur_kind == KIND_CMD);
        ale       = drive_win && (cur_kind == KIND_ADDR);
        dq_oe     = drive_win && !is_read;
        dq_out    = cur_byte;
    end

    // Read capture on the edge where the read strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (phase == PH_LOW && is_read && cnt == '0) begin
            rd_valid <= 1'b1;
            rd_data  <= dq_in;
        end else begin
            rd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nfseq_top.sv
// NAND flash bus cycle sequencer top: wires the controller, the phase
// length calculator and the pin decoder.
// Assumes: clk runs at twice the system clock; the data bus pad combines
// dq_out/dq_oe/dq_in outside this block.
module nfseq_top #(
    parameter int DATA_W     = 8,
    parameter int DLY_W      = 4,
    parameter int LEAD_TICKS = 2,
    parameter int TURN_TICKS = 4,
    parameter int REC_TICKS  = 6,
    parameter int HOLD_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_byte,
    input  logic [DLY_W-1:0]  wr_dly,
    input  logic [DLY_W-1:0]  rd_dly,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    import nfseq_pkg::*;

    localparam int CNT_W = DLY_W + 2;

    phase_e             phase;
    kind_e              cur_kind;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   setup_last;
    logic [CNT_W-1:0]   low_last;
    logic [DATA_W-1:0]  cur_byte;
    logic [DLY_W-1:0]   cur_dly;
    logic               last_was_we;

    nfseq_phase_len #(
        .DLY_W(DLY_W), .CNT_W(CNT_W),
        .LEAD_TICKS(LEAD_TICKS), .TURN_TICKS(TURN_TICKS)
    ) len_i (
        .next_kind  (kind_e'(req_kind)),
        .last_was_we(last_was_we),
        .cur_dly    (cur_dly),
        .setup_last (setup_last),
        .low_last   (low_last)
    );

    nfseq_ctrl #(
        .DATA_W(DATA_W), .DLY_W(DLY_W), .CNT_W(CNT_W), .REC_TICKS(REC_TICKS)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (kind_e'(req_kind)),
        .req_byte   (req_byte),
        .wr_dly     (wr_dly),
        .rd_dly     (rd_dly),
        .setup_last (setup_last),
        .low_last   (low_last),
        .phase      (phase),
        .cnt        (cnt),
        .cur_kind   (cur_kind),
        .cur_byte   (cur_byte),
        .cur_dly    (cur_dly),
        .last_was_we(last_was_we),
        .busy       (busy)
    );

    nfseq_pins #(
        .DATA_W(DATA_W), .CNT_W(CNT_W),
        .REC_TICKS(REC_TICKS), .HOLD_TICKS(HOLD_TICKS)
    ) pins_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .cnt     (cnt),
        .cur_kind(cur_kind),
        .cur_byte(cur_byte),
        .dq_in   (dq_in),
        .ce_n    (ce_n),
        .cle     (cle),
        .ale     (ale),
        .we_n    (we_n),
        .re_n    (re_n),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/nfseq_chk.sv
// Protocol checker for the sequencer pins, attached by bind.
// Assumes: same clock and synchronous active-low reset as the top.
module nfseq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic rd_valid,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic dq_oe
);
    logic [6:0] since_we;

    // Ticks since the write strobe was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            since_we <= 7'd127;
        else if (!we_n)        since_we <= '0;
        else if (since_we != 7'd127) since_we <= since_we + 1'b1;
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    assert_ce_with_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    assert_latch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

    assert_capture_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $rose(re_n)) |-> rd_valid);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $fell(re_n)) |-> (since_we >= 7'd10));

    assert_idle_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !busy);
endmodule

bind nfseq_top nfseq_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_valid(rd_valid),
    .ce_n    (ce_n),
    .cle     (cle),
    .ale     (ale),
    .we_n    (we_n),
    .re_n    (re_n),
    .dq_oe   (dq_oe)
);

// File: tb/nfseq_top_tb_top.sv
// Directed bench for the NAND flash bus cycle sequencer. A negedge monitor
// measures tick counts on the pins; each scenario task checks them.
module nfseq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [7:0] req_byte = 8'h00;
    logic [3:0] wr_dly = 4'd0;
    logic [3:0] rd_dly = 4'd0;
    logic       busy, rd_valid, ce_n, cle, ale, we_n, re_n, dq_oe;
    logic [7:0] rd_data, dq_out;
    logic [7:0] dq_in = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nfseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_byte(req_byte), .wr_dly(wr_dly), .rd_dly(rd_dly), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .ce_n(ce_n), .cle(cle),
        .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
        .dq_in(dq_in)
    );

    // Monitor state, all counted in negedges (ticks).
    int low_run = 0, hi_run = 1000, ce_run = 0, oe_run = 0;
    logic prev_low = 1'b0, prev_cle = 1'b0, prev_oe = 1'b0, prev_ce_n = 1'b1;
    int m_lead, m_gap, m_low_len, m_cle_hold, m_ale_hold, m_oe_hold, m_ce_hold, m_oe_lead;
    logic m_fall_cle, m_fall_ale, m_fall_oe;
    logic prev_ale = 1'b0;
    logic [7:0] m_fall_dq, m_rd_data;
    int n_ce_rise = 0, n_rdv = 0;
    logic [7:0] rd_pattern = 8'h00;

    // Pin measurement and read-data presentation.
    always @(negedge clk) begin
        logic s_low;
        s_low = !we_n || !re_n;
        if (s_low && !prev_low) begin
            m_lead = ce_run; m_gap = hi_run; m_fall_cle = cle; m_fall_ale = ale;
            m_fall_oe = dq_oe; m_fall_dq = dq_out; m_oe_lead = oe_run;
        end
        if (!s_low && prev_low) m_low_len = low_run;
        if (!cle && prev_cle && !s_low) m_cle_hold = hi_run;
        if (!ale && prev_ale && !s_low) m_ale_hold = hi_run;
        if (!dq_oe && prev_oe && !s_low) m_oe_hold = hi_run;
        if (ce_n && !prev_ce_n) begin m_ce_hold = hi_run; n_ce_rise++; end
        if (rd_valid) begin n_rdv++; m_rd_data = rd_data; end
        dq_in = (!re_n && low_run == 2 * (int'(rd_dly) + 1) - 1) ? rd_pattern : ~rd_pattern;
        low_run = s_low ? low_run + 1 : 0;
        hi_run  = s_low ? 0 : (hi_run < 1000 ? hi_run + 1 : hi_run);
        ce_run  = ce_n ? 0 : ce_run + 1;
        oe_run  = dq_oe ? oe_run + 1 : 0;
        prev_low = s_low; prev_cle = cle; prev_ale = ale; prev_oe = dq_oe; prev_ce_n = ce_n;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present a request and hold it until the sequencer takes it.
    task automatic send(input logic [1:0] k, input logic [7:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_byte = b;
        while (busy) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!ce_n || busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 pins idle", {ce_n, we_n, re_n, cle, ale, dq_oe}, 6'b111000);
        chk("R1 busy/valid", {busy, rd_valid}, 0);
    endtask

    task automatic t_command();
        wr_dly = 4'd0;
        send(2'b00, 8'hA5);
        wait_done();
        chk("R2 ce lead", m_lead, 2);
        chk("R3 we low width d0", m_low_len, 2);
        chk("R5 cle at fall", m_fall_cle, 1);
        chk("R5 ale at fall (cmd)", m_fall_ale, 0);
        chk("R5 cle hold", m_cle_hold, 5);
        chk("R6 data at fall", m_fall_dq, 8'hA5);
        chk("R6 oe lead", m_oe_lead, 2);
        chk("R6 oe hold", m_oe_hold, 5);
        chk("R2 ce hold", m_ce_hold, 6);
    endtask

    task automatic t_address();
        wr_dly = 4'd3;
        send(2'b01, 8'h3C);
        wait_done();
        chk("R3 we low width d3", m_low_len, 8);
        chk("R5 ale at fall", m_fall_ale, 1);
        chk("R5 cle at fall (addr)", m_fall_cle, 0);
        chk("R5 ale hold", m_ale_hold, 5);
        chk("R6 addr byte", m_fall_dq, 8'h3C);
    endtask

    task automatic t_back_to_back();
        int rises;
        wr_dly = 4'd2;
        rises = n_ce_rise;
        send(2'b10, 8'h11);
        send(2'b10, 8'h22);
        wait_done();
        chk("R4 strobe high gap", m_gap, 8);
        chk("R4 ce rises once", n_ce_rise - rises, 1);
        chk("R3 we low width d2", m_low_len, 6);
        chk("R5 no latch on data", {m_fall_cle, m_fall_ale}, 0);
        chk("R6 second byte", m_fall_dq, 8'h22);
    endtask

    task automatic t_reads();
        int nv;
        rd_dly = 4'd1;
        rd_pattern = 8'h5A;
        nv = n_rdv;
        send(2'b11, 8'h00);
        wait_done();
        chk("R8 read after write lead", m_lead, 4);
        chk("R3 re low width d1", m_low_len, 4);
        chk("R7 no drive on read", m_fall_oe, 0);
        chk("R7 one valid pulse", n_rdv - nv, 1);
        chk("R7 captured byte", m_rd_data, 8'h5A);
        rd_pattern = 8'h96;
        send(2'b11, 8'h00);
        wait_done();
        chk("R2 read after read lead", m_lead, 2);
        chk("R7 second byte", m_rd_data, 8'h96);
        chk("R7 two pulses total", n_rdv - nv, 2);
    endtask

    task automatic t_write_then_read();
        int rises;
        wr_dly = 4'd1;
        rd_dly = 4'd0;
        rd_pattern = 8'hC3;
        rises = n_ce_rise;
        send(2'b00, 8'h70);
        send(2'b11, 8'h00);
        wait_done();
        chk("R8 turnaround gap", m_gap, 10);
        chk("R3 re low width d0", m_low_len, 2);
        chk("R7 byte after turnaround", m_rd_data, 8'hC3);
        chk("R4 ce held across pair", n_ce_rise - rises, 1);
    endtask

    task automatic t_latch_delay();
        wr_dly = 4'd1;
        send(2'b10, 8'h0F);
        chk("R9 busy during cycle", busy, 1);
        wr_dly = 4'd7;
        wait_done();
        chk("R10 delay latched", m_low_len, 4);
    endtask

    task automatic t_max_delay();
        wr_dly = 4'd15;
        send(2'b10, 8'hF0);
        wait_done();
        chk("R3 we low width d15", m_low_len, 32);
        chk("R9 idle not busy", busy, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_command();
        t_address();
        t_back_to_back();
        t_reads();
        t_write_then_read();
        t_latch_delay();
        t_max_delay();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule